// File: doc/BRIEF.md
# Code-Aware Re-Reference Replacement Controller

This block keeps a 2-bit re-reference prediction for every line of a set-associative cache and chooses the way to evict when the cache asks for a victim in a set. A prediction of 0 means the line is expected back soon, and 3 means it is not expected back for a long time. Only lines at 3 may be evicted. When a set holds none, every line in that set ages by one step per clock cycle until some line reaches 3.

Instruction lines are favoured over data lines at fill time. A data fill enters at 3, so it is the first to leave. A code fill enters at 2, so it outlives data that arrived at the same time. A hit pulls the line back to 0. An empty way is always preferred over aging. While a set is being searched, hits and fills aimed at that set are held back through per-port ready signals. Tags, data arrays and miss handling belong to the surrounding cache.

Top module: `code_rrip_repl`

## Requirements
- R1: After reset every line is invalid with prediction 3. `busy` and `vic_valid` are low, and `hit_rdy` and `fill_rdy` are high.
- R2: An accepted hit (`hit_en` high while `hit_rdy` is high) sets that line's prediction to 0 on the next clock edge.
- R3: An accepted fill makes the line valid. Its prediction becomes 3 when `fill_code` is 0 (data) and 2 when `fill_code` is 1 (code).
- R4: If the searched set has an invalid way, the lowest-index invalid way is returned in the first search cycle and nothing is aged. This gives a latency of 1 cycle from the accepting edge.
- R5: Otherwise, if any valid way holds prediction 3, the lowest-index such way is returned in the first search cycle.
- R6: Otherwise, every way of the set is incremented by one on each search cycle until a way reaches 3, and `vic_valid` rises in the first cycle a 3 exists. There are never more than three aging steps, so the latency is at most 4 cycles.
- R7: While a search is in progress, `hit_rdy` and `fill_rdy` are low for requests whose set matches the searched set, and such requests have no effect. Requests to other sets are accepted.
- R8: Each request accepted while idle produces exactly one one-cycle `vic_valid` pulse, after which `busy` is low. A `vreq` raised while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_en | input | 1 | Hit update request |
| hit_set | input | SW | Set of the hit line |
| hit_way | input | WW | Way of the hit line |
| hit_rdy | output | 1 | Hit update may be applied this cycle |
| fill_en | input | 1 | Fill update request |
| fill_set | input | SW | Set being filled |
| fill_way | input | WW | Way being filled |
| fill_code | input | 1 | 1 = instruction line, 0 = data line |
| fill_rdy | output | 1 | Fill may be applied this cycle |
| vreq | input | 1 | Victim request, accepted when idle |
| vreq_set | input | SW | Set to search for a victim |
| busy | output | 1 | A search is in progress |
| vic_valid | output | 1 | Victim way is valid this cycle |
| vic_way | output | WW | Chosen victim way |

## Verification
The assertions rely on the requester keeping `hit_en` and `fill_en` low unless the matching ready is high, or on the block dropping such requests. They also rely on the set and way indices staying within the configured counts. The stimulus respects this: every table fill and hit waits on its ready. The single deliberate violation is a hit held against the searched set to show that it is ignored. Expected victims and latencies are derived by hand from the insertion values and the aging rule.

// File: rtl/code_rrip_repl.sv
module code_rrip_repl #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int SW = $clog2(SETS),
  localparam int WW = $clog2(WAYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_en,
  input  logic [SW-1:0] hit_set,
  input  logic [WW-1:0] hit_way,
  output logic          hit_rdy,
  input  logic          fill_en,
  input  logic [SW-1:0] fill_set,
  input  logic [WW-1:0] fill_way,
  input  logic          fill_code,
  output logic          fill_rdy,
  input  logic          vreq,
  input  logic [SW-1:0] vreq_set,
  output logic          busy,
  output logic          vic_valid,
  output logic [WW-1:0] vic_way
);

  logic [1:0]      rrpv [SETS][WAYS];
  logic [WAYS-1:0] vld  [SETS];
  logic            srch;
  logic [SW-1:0]   cur;
  logic            inv_hit, dist_hit;
  logic [WW-1:0]   inv_way, dist_way;

  assign busy     = srch;
  assign hit_rdy  = !(srch && hit_set == cur);
  assign fill_rdy = !(srch && fill_set == cur);

  wire hit_go  = hit_en && hit_rdy;
  wire fill_go = fill_en && fill_rdy;
  wire found   = inv_hit || dist_hit;
  wire age     = srch && !found;

  always_comb begin
    inv_hit  = 1'b0;
    dist_hit = 1'b0;
    inv_way  = '0;
    dist_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld[cur][w]) begin
        inv_hit = 1'b1;
        inv_way = WW'(w);
      end
      if (rrpv[cur][w] == 2'd3) begin
        dist_hit = 1'b1;
        dist_way = WW'(w);
      end
    end
  end

  assign vic_valid = srch && found;
  assign vic_way   = inv_hit ? inv_way : dist_way;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      srch <= 1'b0;
      cur  <= '0;
      for (int s = 0; s < SETS; s++) begin
        vld[s] <= '0;
        for (int w = 0; w < WAYS; w++) rrpv[s][w] <= 2'd3;
      end
    end else begin
      if (!srch && vreq) begin
        srch <= 1'b1;
        cur  <= vreq_set;
      end else if (vic_valid) begin
        srch <= 1'b0;
      end
      if (age)
        for (int w = 0; w < WAYS; w++) rrpv[cur][w] <= rrpv[cur][w] + 2'd1;
      if (hit_go)
        rrpv[hit_set][hit_way] <= 2'd0;
      if (fill_go) begin
        vld[fill_set][fill_way]  <= 1'b1;
        rrpv[fill_set][fill_way] <= fill_code ? 2'd2 : 2'd3;
      end
    end
  end

  logic [2:0] age_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n || !srch) age_cnt <= '0;
    else if (age) age_cnt <= age_cnt + 3'd1;
  end

  // R6
  aging_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    age_cnt <= 3'd3);

  // R3
  data_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_go && !fill_code |=> rrpv[$past(fill_set)][$past(fill_way)] == 2'd3);

  // R3
  code_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_go && fill_code |=> rrpv[$past(fill_set)][$past(fill_way)] == 2'd2);

  // R2
  hit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_go && !(fill_go && fill_set == hit_set && fill_way == hit_way)
    |=> rrpv[$past(hit_set)][$past(hit_way)] == 2'd0);

  // R8
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid |=> !busy && !vic_valid);

  // R8
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && vreq |=> busy && cur == $past(vreq_set));

endmodule

// File: tb/test_code_rrip_repl.sv
module test_code_rrip_repl;
  localparam int SW = 4, WW = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hit_en = 0, fill_en = 0, fill_code = 0, vreq = 0;
  logic [SW-1:0] hit_set = '0, fill_set = '0, vreq_set = '0;
  logic [WW-1:0] hit_way = '0, fill_way = '0;
  logic hit_rdy, fill_rdy, busy, vic_valid;
  logic [WW-1:0] vic_way;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  code_rrip_repl #(.SETS(16), .WAYS(4)) i_code_rrip_repl (
    .clk(clk), .rst_n(rst_n),
    .hit_en(hit_en), .hit_set(hit_set), .hit_way(hit_way), .hit_rdy(hit_rdy),
    .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way),
    .fill_code(fill_code), .fill_rdy(fill_rdy),
    .vreq(vreq), .vreq_set(vreq_set), .busy(busy),
    .vic_valid(vic_valid), .vic_way(vic_way));

  // op[13:12] 0=fill 1=hit 2=request, set[11:8], way[7:6], code[5], exp way[4:3], exp latency[2:0]
  localparam int NV = 27;
  localparam logic [13:0] VEC [NV] = '{
    {2'd0,4'd1,2'd0,1'b1,2'd0,3'd0}, {2'd0,4'd1,2'd1,1'b0,2'd0,3'd0},
    {2'd0,4'd1,2'd2,1'b1,2'd0,3'd0}, {2'd0,4'd1,2'd3,1'b1,2'd0,3'd0},
    {2'd2,4'd1,2'd0,1'b0,2'd1,3'd1},
    {2'd0,4'd1,2'd1,1'b1,2'd0,3'd0},
    {2'd2,4'd1,2'd0,1'b0,2'd0,3'd2},
    {2'd1,4'd1,2'd0,1'b0,2'd0,3'd0},
    {2'd2,4'd1,2'd0,1'b0,2'd1,3'd1},
    {2'd1,4'd1,2'd0,1'b0,2'd0,3'd0}, {2'd1,4'd1,2'd1,1'b0,2'd0,3'd0},
    {2'd1,4'd1,2'd2,1'b0,2'd0,3'd0}, {2'd1,4'd1,2'd3,1'b0,2'd0,3'd0},
    {2'd2,4'd1,2'd0,1'b0,2'd0,3'd4},
    {2'd0,4'd2,2'd0,1'b0,2'd0,3'd0}, {2'd0,4'd2,2'd1,1'b0,2'd0,3'd0},
    {2'd0,4'd2,2'd3,1'b0,2'd0,3'd0},
    {2'd2,4'd2,2'd0,1'b0,2'd2,3'd1},
    {2'd0,4'd2,2'd2,1'b1,2'd0,3'd0},
    {2'd2,4'd2,2'd0,1'b0,2'd0,3'd1},
    {2'd2,4'd0,2'd0,1'b0,2'd0,3'd1},
    {2'd0,4'd3,2'd0,1'b1,2'd0,3'd0}, {2'd0,4'd3,2'd1,1'b1,2'd0,3'd0},
    {2'd0,4'd3,2'd2,1'b1,2'd0,3'd0}, {2'd0,4'd3,2'd3,1'b1,2'd0,3'd0},
    {2'd1,4'd3,2'd2,1'b0,2'd0,3'd0},
    {2'd2,4'd3,2'd0,1'b0,2'd0,3'd2}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_fill(input logic [SW-1:0] s, input logic [WW-1:0] w, input logic c);
    @(negedge clk);
    fill_en = 1; fill_set = s; fill_way = w; fill_code = c;
    while (!fill_rdy) @(negedge clk);
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic do_hit(input logic [SW-1:0] s, input logic [WW-1:0] w);
    @(negedge clk);
    hit_en = 1; hit_set = s; hit_way = w;
    while (!hit_rdy) @(negedge clk);
    @(negedge clk);
    hit_en = 0;
  endtask

  task automatic do_req(input logic [SW-1:0] s, input int ew, input int el, input string req);
    int lat;
    @(negedge clk);
    vreq = 1; vreq_set = s;
    @(negedge clk);
    vreq = 0;
    lat = 1;
    while (!vic_valid && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    check(vic_way == WW'(ew), {req, " victim way"}, vic_way, ew);
    check(lat == el, {req, " latency"}, lat, el);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset outputs
    check(!busy && !vic_valid, "R1 idle after reset", {busy, vic_valid}, 0);
    check(hit_rdy && fill_rdy, "R1 ready after reset", {hit_rdy, fill_rdy}, 3);

    for (int i = 0; i < NV; i++) begin
      logic [13:0] v;
      v = VEC[i];
      case (v[13:12])
        2'd0: do_fill(v[11:8], v[7:6], v[5]);
        2'd1: do_hit(v[11:8], v[7:6]);
        default: do_req(v[11:8], v[4:3], v[2:0],
                        v[2:0] > 3'd1 ? "R6 aging" : "R4/R5 direct");
      endcase
    end

    // R3 code fill outlives data fill in the same set
    do_fill(4'd5, 2'd0, 1'b1);
    do_fill(4'd5, 2'd1, 1'b0);
    do_fill(4'd5, 2'd2, 1'b1);
    do_fill(4'd5, 2'd3, 1'b1);
    do_req(4'd5, 1, 1, "R3 data fill first out");

    // R7 hold-off: hit to the searched set is ignored, other sets are ready
    for (int w = 0; w < 4; w++) do_hit(4'd1, WW'(w));
    @(negedge clk);
    vreq = 1; vreq_set = 4'd1;
    @(negedge clk);
    vreq = 0;
    hit_en = 1; hit_set = 4'd1; hit_way = 2'd0;
    fill_set = 4'd6;
    #0;
    check(busy, "R8 busy during search", busy, 1);
    check(!hit_rdy, "R7 hit_rdy low on searched set", hit_rdy, 0);
    check(fill_rdy, "R7 fill_rdy high on other set", fill_rdy, 1);
    // R8 request raised during search must not redirect it
    vreq = 1; vreq_set = 4'd0;
    lat = 1;
    while (!vic_valid && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    hit_en = 0; vreq = 0;
    check(vic_way == 2'd0, "R7 blocked hit ignored, victim way", vic_way, 0);
    check(lat == 4, "R7 blocked hit ignored, latency", lat, 4);
    @(negedge clk);
    check(!busy && !vic_valid, "R8 single pulse then idle", {busy, vic_valid}, 0);

    // R2 hit on set 3 pulls way 0,1,3 to 0; way 2 sits at 1 after aging
    do_hit(4'd3, 2'd0);
    do_hit(4'd3, 2'd1);
    do_hit(4'd3, 2'd3);
    do_req(4'd3, 2, 3, "R2/R6 hit resets prediction");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule